// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Selective Invalidation

This block is a small fully associative translation cache for an I/O memory management unit. Each line keeps a 7-bit address-space tag, the upper 20 bits of a 32-bit virtual address (the 4 KiB page number), a physical frame number, and three permission bits. A client presents an address-space tag and a virtual address on the lookup port. One clock later the block returns a hit flag together with the frame and permissions of the matching line.

After an external page walk completes, the walker writes the result through the fill port. The block picks the line to write. A line that already holds the same tag and page number is rewritten in place. Otherwise the block takes an empty line, and when no line is empty it takes the line named by a rotating pointer. A configuration input limits how many lines are in use.

Invalidation comes as one 32-bit command word. The word can optionally restrict the flush to one address-space tag, and it chooses one of three address scopes: every address, one 4 MiB section, or one 16 KiB group.

Top module: `iotlb_cache`

## Requirements
- R1: After reset every line is empty: `lk_hit` is 0 and no lookup hits until a fill has been made.
- R2: A lookup with `lk_valid` high returns its result on the next clock. `lk_hit`=1 only when a valid, active line matches both the tag and `lk_va[31:12]`; in that case `lk_pfn` and `lk_perm` hold that line's contents. On a miss, or when `lk_valid` is low, all three outputs are 0. `lk_va[11:0]` is ignored.
- R3: A fill whose tag and page number equal those of a valid active line overwrites that line. Otherwise it writes the lowest-index empty active line. If no active line is empty, it writes the line at the rotating pointer and moves the pointer to the next active line, wrapping to 0. The pointer starts at 0 and is treated as 0 when it lies at or above `cfg_lines`.
- R4: Only lines with index below `cfg_lines` can hit or be filled. When `cfg_lines` is 0, every lookup misses and fills are dropped.
- R5: When `flush_cmd[1:0]`=0 and `flush_cmd[31]`=0, a flush empties every line.
- R6: When `flush_cmd[31]`=1, a flush affects only lines whose tag equals `flush_cmd[30:24]`.
- R7: When `flush_cmd[1:0]`=2, a flush affects only lines whose `va[31:22]` (page bits [19:10]) equals `flush_cmd[19:10]`. `flush_cmd[9:2]` is ignored in this mode.
- R8: When `flush_cmd[1:0]`=3, a flush affects only lines whose `va[31:14]` (page bits [19:2]) equals `flush_cmd[19:2]`.
- R9: A flush with `flush_cmd[1:0]`=1 changes nothing.
- R10: A lookup in the same cycle as a flush or a fill sees the contents from before that cycle. When a fill and a flush share a cycle, the flush is applied first, the victim is chosen from the state before the cycle, and the filled line is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lines | input | CNT_W | Number of active lines (0..ENTRIES) |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space tag |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_pfn | output | PFN_W | Frame number of the hit line |
| lk_perm | output | 3 | Permissions {read, write, nonsecure} |
| fill_en | input | 1 | Write a translation |
| fill_asid | input | 7 | Tag of the new line |
| fill_vpn | input | 20 | Page number (va[31:12]) of the new line |
| fill_pfn | input | PFN_W | Frame number of the new line |
| fill_perm | input | 3 | Permissions of the new line |
| flush_en | input | 1 | Apply flush_cmd this cycle |
| flush_cmd | input | 32 | Encoded invalidation command |

## Verification
The hardest state to reach is a full cache in which section and group flushes hit some lines and miss others that share a tag or a section. Once some lines are gone, later fills must land in the lowest empty slot again and not at the rotating pointer. To get there, the random stimulus draws tags, sections and groups from small pools, so collisions and partial flushes happen often. A bench model tracks the empty slots and the pointer. Directed sequences cover the case where the cache is full and the pointer wraps, the case where `cfg_lines` shrinks, and the cases where a fill or a flush shares a cycle with a lookup.

// File: rtl/iotlb_cache.sv
module iotlb_cache #(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic             lk_valid,
  input  logic [6:0]       lk_asid,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [2:0]       lk_perm,
  input  logic             fill_en,
  input  logic [6:0]       fill_asid,
  input  logic [19:0]      fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm,
  input  logic             flush_en,
  input  logic [31:0]      flush_cmd
);
  logic [ENTRIES-1:0] vld, active, hit_vec, same_vec, empty_vec, fl_vec;
  logic [6:0]       t_asid [ENTRIES];
  logic [19:0]      t_vpn  [ENTRIES];
  logic [PFN_W-1:0] t_pfn  [ENTRIES];
  logic [2:0]       t_perm [ENTRIES];
  logic [IDX_W-1:0] rr, rr_eff, vic;
  logic             use_rr, do_fill;
  logic [PFN_W-1:0] pfn_m;
  logic [2:0]       perm_m;

  logic unused_bits;
  assign unused_bits = ^{lk_va[11:0], flush_cmd[23:20]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_line
    logic va_ok;
    assign active[i]    = CNT_W'(i) < cfg_lines;
    assign hit_vec[i]   = vld[i] & active[i] & (t_asid[i] == lk_asid) & (t_vpn[i] == lk_va[31:12]);
    assign same_vec[i]  = vld[i] & active[i] & (t_asid[i] == fill_asid) & (t_vpn[i] == fill_vpn);
    assign empty_vec[i] = ~vld[i] & active[i];
    always_comb
      case (flush_cmd[1:0])
        2'd0:    va_ok = 1'b1;
        2'd2:    va_ok = t_vpn[i][19:10] == flush_cmd[19:10];
        2'd3:    va_ok = t_vpn[i][19:2] == flush_cmd[19:2];
        default: va_ok = 1'b0;
      endcase
    assign fl_vec[i] = flush_en & va_ok & (~flush_cmd[31] | (t_asid[i] == flush_cmd[30:24]));
  end

  assign rr_eff  = (CNT_W'(rr) < cfg_lines) ? rr : '0;
  assign do_fill = fill_en & (cfg_lines != '0);

  always_comb begin
    vic    = rr_eff;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (empty_vec[i]) begin vic = IDX_W'(i); use_rr = 1'b0; end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (same_vec[i]) begin vic = IDX_W'(i); use_rr = 1'b0; end
  end

  always_comb begin
    pfn_m  = '0;
    perm_m = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) begin pfn_m |= t_pfn[i]; perm_m |= t_perm[i]; end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld     <= '0;
      rr      <= '0;
      lk_hit  <= 1'b0;
      lk_pfn  <= '0;
      lk_perm <= '0;
    end else begin
      lk_hit  <= lk_valid & (|hit_vec);
      lk_pfn  <= lk_valid ? pfn_m : '0;
      lk_perm <= lk_valid ? perm_m : '0;
      vld     <= (vld & ~fl_vec) | (do_fill ? (ENTRIES'(1) << vic) : '0);
      if (do_fill && use_rr)
        rr <= (CNT_W'(vic) + CNT_W'(1) >= cfg_lines) ? '0 : vic + IDX_W'(1);
    end

  always_ff @(posedge clk)
    if (do_fill) begin
      t_asid[vic] <= fill_asid;
      t_vpn[vic]  <= fill_vpn;
      t_pfn[vic]  <= fill_pfn;
      t_perm[vic] <= fill_perm;
    end

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n) lk_hit |-> $past(lk_valid));
  assert_fill_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ((vld & ~$past(vld) & ~$past(active)) == '0));
  assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !flush_cmd[31] && flush_cmd[1:0] == 2'd0 && !fill_en) |=> (vld == '0));
  assert_reserved_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && flush_cmd[1:0] == 2'd1 && !fill_en) |=> $stable(vld));
endmodule

// File: tb/iotlb_cache_tb.sv
module iotlb_cache_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_lines = 4'd8;
  logic lk_valid = 0, fill_en = 0, flush_en = 0;
  logic [6:0] lk_asid = 0, fill_asid = 0;
  logic [31:0] lk_va = 0, flush_cmd = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0, lk_pfn;
  logic [2:0] fill_perm = 0, lk_perm;
  logic lk_hit;

  always #10 clk = ~clk;

  iotlb_cache u_dut (.clk, .rst_n, .cfg_lines, .lk_valid, .lk_asid, .lk_va, .lk_hit, .lk_pfn,
    .lk_perm, .fill_en, .fill_asid, .fill_vpn, .fill_pfn, .fill_perm, .flush_en, .flush_cmd);

  int checks = 0, errors = 0;
  bit m_v [N];
  logic [6:0] m_a [N];
  logic [19:0] m_vp [N], m_pf [N];
  logic [2:0] m_pm [N];
  int m_rr = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit flush_hits(int i, logic [31:0] c);
    bit va_ok;
    case (c[1:0])
      2'd0: va_ok = 1;
      2'd2: va_ok = m_vp[i][19:10] == c[19:10];
      2'd3: va_ok = m_vp[i][19:2] == c[19:2];
      default: va_ok = 0;
    endcase
    return va_ok && (!c[31] || m_a[i] == c[30:24]);
  endfunction

  task automatic model_step(input bit fe, input bit fle, input logic [31:0] fc);
    int vic, lines;
    bit found;
    lines = int'(cfg_lines);
    vic = -1; found = 0;
    if (fe && lines > 0) begin
      for (int i = 0; i < lines; i++)
        if (!found && m_v[i] && m_a[i] == fill_asid && m_vp[i] == fill_vpn) begin vic = i; found = 1; end
      for (int i = 0; i < lines; i++)
        if (!found && !m_v[i]) begin vic = i; found = 1; end
      if (!found) begin
        vic = (m_rr < lines) ? m_rr : 0;
        m_rr = (vic + 1 >= lines) ? 0 : vic + 1;
      end
    end
    if (fle) for (int i = 0; i < N; i++) if (m_v[i] && flush_hits(i, fc)) m_v[i] = 0;
    if (vic >= 0) begin
      m_v[vic] = 1; m_a[vic] = fill_asid; m_vp[vic] = fill_vpn;
      m_pf[vic] = fill_pfn; m_pm[vic] = fill_perm;
    end
  endtask

  // want: 0 miss, 1 hit, 2 don't care (model only)
  task automatic cyc(input bit fe, input logic [6:0] fa, input logic [19:0] fv, input logic [19:0] fp,
                     input bit fle, input logic [31:0] fc,
                     input bit le, input logic [6:0] la, input logic [19:0] lv,
                     input int want, input string tag);
    bit eh; logic [19:0] ep; logic [2:0] em;
    fill_en = fe; fill_asid = fa; fill_vpn = fv; fill_pfn = fp; fill_perm = fp[2:0];
    flush_en = fle; flush_cmd = fc;
    lk_valid = le; lk_asid = la; lk_va = {lv, 12'($urandom)};
    eh = 0; ep = 0; em = 0;
    if (le) for (int i = 0; i < int'(cfg_lines); i++)
      if (m_v[i] && m_a[i] == la && m_vp[i] == lv) begin eh = 1; ep = m_pf[i]; em = m_pm[i]; end
    model_step(fe, fle, fc);
    @(negedge clk);
    if (le) begin
      check(tag, 32'(lk_hit), 32'(eh));
      check(tag, 32'(lk_pfn), 32'(ep));
      check(tag, 32'(lk_perm), 32'(em));
      if (want != 2) check({tag, " directed"}, 32'(lk_hit), 32'(want));
    end else check(tag, {lk_hit, lk_pfn, lk_perm}, 32'd0);
    fill_en = 0; flush_en = 0; lk_valid = 0;
  endtask

  task automatic fill(input logic [6:0] a, input logic [19:0] v, input logic [19:0] p);
    cyc(1, a, v, p, 0, 0, 0, 0, 0, 2, "R3");
  endtask
  task automatic look(input logic [6:0] a, input logic [19:0] v, input int want, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, a, v, want, tag);
  endtask
  task automatic flush(input logic [31:0] c, input string tag);
    cyc(0, 0, 0, 0, 1, c, 0, 0, 0, 2, tag);
  endtask

  function automatic logic [19:0] key(int s, int g, int l);
    return {8'h0, 2'(s), 6'h0, 2'(g), 2'(l)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset hit", 32'(lk_hit), 0);
    rst_n = 1;
    @(negedge clk);
    look(7'd3, key(0, 0, 0), 0, "R1");
    // basic hit / miss
    fill(7'd3, key(1, 1, 1), 20'hABC05);
    look(7'd3, key(1, 1, 1), 1, "R2");
    look(7'd4, key(1, 1, 1), 0, "R2 other tag");
    look(7'd3, key(1, 1, 2), 0, "R2 other page");
    // lookup same cycle as fill sees old state
    cyc(1, 7'd3, key(2, 0, 0), 20'h11112, 0, 0, 1, 7'd3, key(2, 0, 0), 0, "R10 fill");
    look(7'd3, key(2, 0, 0), 1, "R10 after fill");
    // flush all
    flush(32'h0, "R5");
    look(7'd3, key(1, 1, 1), 0, "R5");
    // fill full then evict via pointer
    for (int i = 0; i < N; i++) fill(7'd5, key(0, i % 4, i / 4), 20'(i + 16));
    fill(7'd5, key(3, 3, 3), 20'h777);
    look(7'd5, key(0, 0, 0), 0, "R3 evict first");
    look(7'd5, key(0, 1, 0), 1, "R3 keep second");
    fill(7'd5, key(3, 3, 3), 20'h999);
    look(7'd5, key(3, 3, 3), 1, "R3 overwrite");
    fill(7'd5, key(2, 2, 2), 20'h4444);
    look(7'd5, key(0, 1, 0), 0, "R3 pointer advanced");
    // reserved mode
    flush(32'h8500_0001, "R9");
    look(7'd5, key(3, 3, 3), 1, "R9");
    // tag-restricted, section, group
    flush(32'h0, "R5");
    fill(7'd5, key(1, 0, 0), 20'h1); fill(7'd6, key(1, 0, 0), 20'h2);
    fill(7'd5, key(2, 1, 0), 20'h3); fill(7'd5, key(2, 2, 0), 20'h4);
    flush({1'b1, 7'd6, 24'h0}, "R6");
    look(7'd6, key(1, 0, 0), 0, "R6 flushed");
    look(7'd5, key(1, 0, 0), 1, "R6 kept");
    flush({1'b0, 7'd0, 4'h0, key(1, 3, 0)[19:2], 2'd2}, "R7");
    look(7'd5, key(1, 0, 0), 0, "R7 flushed");
    look(7'd5, key(2, 1, 0), 1, "R7 kept");
    flush({1'b1, 7'd5, 4'h0, key(2, 1, 0)[19:2], 2'd3}, "R8");
    look(7'd5, key(2, 1, 0), 0, "R8 flushed");
    look(7'd5, key(2, 2, 0), 1, "R8 kept");
    // flush same cycle as lookup
    cyc(0, 0, 0, 0, 1, 32'h0, 1, 7'd5, key(2, 2, 0), 1, "R10 flush");
    look(7'd5, key(2, 2, 0), 0, "R10 after flush");
    // active line limit
    for (int i = 0; i < 5; i++) fill(7'd9, key(0, i % 4, i / 4), 20'(i + 32));
    cfg_lines = 4'd2;
    look(7'd9, key(0, 3, 0), 0, "R4 beyond limit");
    look(7'd9, key(0, 1, 0), 1, "R4 within limit");
    fill(7'd9, key(3, 0, 0), 20'h55);
    look(7'd9, key(0, 0, 0), 0, "R4 evicted in range");
    cfg_lines = 4'd0;
    fill(7'd9, key(3, 1, 1), 20'h66);
    look(7'd9, key(0, 1, 0), 0, "R4 zero lines");
    cfg_lines = 4'd8;
    look(7'd9, key(3, 1, 1), 0, "R4 dropped fill");
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a; logic [19:0] v; logic [31:0] c;
      a = (($urandom % 3) == 0) ? 7'h7f : 7'($urandom % 3);
      v = key($urandom % 4, $urandom % 4, $urandom % 4);
      c = {1'($urandom), 7'($urandom % 3), 4'h0, key($urandom % 4, $urandom % 4, $urandom % 4)[19:2], 2'($urandom)};
      if (n % 500 == 499) cfg_lines = 4'($urandom % 9);
      cyc(($urandom % 3) == 0, a, v, 20'($urandom), ($urandom % 9) == 0, c,
          ($urandom % 4) != 0, 7'(($urandom % 2) ? a : 7'($urandom % 3)),
          key($urandom % 4, $urandom % 4, $urandom % 4), 2, "R2 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule